// File: doc/BRIEF.md
# Ones-Density Violation Monitor

This block watches a serial line bit stream on its way to the transmitter. It takes one bit on each clock where a valid strobe is high. It reports when the stream breaks the T1 ones-density rule. The rule has two parts. The first limits how many zeros may follow one another. The second sets a family of minimum ones counts, one for each of 23 nested window lengths. All of these are checked at the same time on every accepted bit.

Any breach sets a sticky flag. The flag stays set until software clears it by writing a 1 through a write strobe. An enable input gates the flag onto an interrupt request. Line coding, framing and zero-substitution codes are handled elsewhere. This block only judges the raw bits it is given.

Top module: `ones_density_checker`

## Requirements
- R1: If 16 or more zeros in a row are accepted, the flag is 1 on the clock edge that accepts the 16th zero. A run of only 15 zeros, followed by a 1, does not set the flag by itself.
- R2: For each N from 1 to 23, the most recent 8×(N+1) accepted bits must hold at least N ones. If any such window holds fewer, the flag is set on the edge that accepts the bit completing that window.
- R3: A window of length 8×(N+1) is not judged until that many bits have been accepted since reset. A short start-up prefix with few ones therefore raises no flag.
- R4: Once set, the flag stays 1 until it is cleared, even after the stream becomes compliant again, and also while no bits arrive.
- R5: A write with the strobe high and the written value 1 clears the flag on the next edge. A write of value 0 leaves the flag unchanged. A value of 1 presented without the strobe also leaves it unchanged.
- R6: When a clear write and a new violation meet on the same edge, the flag remains 1.
- R7: The interrupt output is 1 exactly when the flag is 1 and the enable input is 1. It follows the enable input without a clock delay.
- R8: A cycle where the valid strobe is low leaves the bit history untouched, whatever the data input holds.
- R9: After reset, the flag and the interrupt are 0, and the history, the counters and the zero-run count are empty.
- R10: A stream with exactly one 1 in every 8 bits never sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | High when bit_data carries a stream bit |
| bit_data | input | 1 | Serial stream bit |
| clr_wr | input | 1 | Write strobe for the flag clear |
| clr_val | input | 1 | Value written; 1 clears the flag, 0 does nothing |
| irq_en | input | 1 | Interrupt enable; 0 masks the request |
| viol_flag | output | 1 | Sticky density-violation flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the reset is the only way the history is emptied. They also assume that bit_valid and bit_data are stable at each clock edge. The clear strobe may coincide with any stream activity. The bench drives every input on the falling edge, so these assumptions always hold. Clears and valid gaps are mixed freely into both the random and the directed streams. Random ones density is kept near the legal limit, so that the window checks and the zero-run check both switch often.

// File: rtl/ones_density_checker.sv
module ones_density_checker #(
  parameter int WIN_UNIT     = 8,
  parameter int NUM_WIN      = 23,
  parameter int MAX_ZERO_RUN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic clr_wr,
  input  logic clr_val,
  input  logic irq_en,
  output logic viol_flag,
  output logic irq
);
  localparam int HIST_LEN = WIN_UNIT * (NUM_WIN + 1);
  localparam int CW       = $clog2(HIST_LEN + 1);
  localparam int ZSAT     = MAX_ZERO_RUN + 1;
  localparam int ZW       = $clog2(ZSAT + 1);

  logic [HIST_LEN-1:0] hist;
  logic [CW-1:0]       fill, fill_nx;
  logic [ZW-1:0]       zrun, zrun_nx;
  logic [NUM_WIN-1:0]  win_low;
  logic                zero_viol, viol;

  assign fill_nx   = (fill == CW'(HIST_LEN)) ? fill : fill + CW'(1);
  assign zrun_nx   = bit_data ? '0 : ((zrun == ZW'(ZSAT)) ? zrun : zrun + ZW'(1));
  assign zero_viol = (zrun_nx == ZW'(ZSAT));
  assign viol      = bit_valid & (zero_viol | (|win_low));
  assign irq       = viol_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      fill <= '0;
      zrun <= '0;
    end else if (bit_valid) begin
      hist <= {hist[HIST_LEN-2:0], bit_data};
      fill <= fill_nx;
      zrun <= zrun_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_flag <= 1'b0;
    else        viol_flag <= viol | (viol_flag & ~(clr_wr & clr_val));
  end

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam int LEN  = WIN_UNIT * (k + 2);
    localparam int NEED = k + 1;
    logic [CW-1:0] cnt, cnt_nx;
    logic          leave;

    assign leave      = (fill >= CW'(LEN)) ? hist[LEN-1] : 1'b0;
    assign cnt_nx     = cnt + CW'(bit_data) - CW'(leave);
    assign win_low[k] = (fill_nx >= CW'(LEN)) && (cnt_nx < CW'(NEED));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (bit_valid) cnt <= cnt_nx;
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt <= fill) && (cnt <= CW'(LEN)));
  end

  p_zrun_sat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= ZW'(ZSAT));

  p_run_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !bit_data && (zrun >= ZW'(MAX_ZERO_RUN)) |=> viol_flag);

  p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag && !(clr_wr && clr_val) |=> viol_flag);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && clr_val && !viol |=> !viol_flag);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol_flag);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(hist) && $stable(fill) && $stable(zrun));

  p_rise_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_flag) |-> $past(bit_valid));
endmodule

// File: tb/ones_density_checker_tb.sv
module ones_density_checker_tb;
  localparam int HL = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_data = 1'b0, clr_wr = 1'b0, clr_val = 1'b0, irq_en = 1'b0;
  logic viol_flag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit [HL-1:0] mh;
  int mfill, mz;
  bit exp_flag;

  always #4 clk = ~clk;

  ones_density_checker u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .clr_wr(clr_wr), .clr_val(clr_val), .irq_en(irq_en),
    .viol_flag(viol_flag), .irq(irq)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  function automatic bit model_window_viol();
    bit v = 1'b0;
    for (int n = 1; n <= 23; n++) begin
      int len = 8 * (n + 1);
      if (mfill >= len) begin
        int ones = 0;
        for (int i = 0; i < len; i++) ones += int'(mh[i]);
        if (ones < n) v = 1'b1;
      end
    end
    return v;
  endfunction

  task automatic cyc(input bit v, input bit d, input bit cw, input bit cv, input bit en, input string tag);
    bit nv = 1'b0;
    bit_valid = v; bit_data = d; clr_wr = cw; clr_val = cv; irq_en = en;
    @(posedge clk);
    if (v) begin
      mh = {mh[HL-2:0], d};
      if (mfill < HL) mfill++;
      mz = d ? 0 : ((mz < 16) ? mz + 1 : 16);
      nv = (mz >= 16) || model_window_viol();
    end
    exp_flag = nv | (exp_flag & !(cw & cv));
    @(negedge clk);
    check(viol_flag, exp_flag, tag, "viol_flag");
    check(irq, exp_flag & en, tag, "irq");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_valid = 0; bit_data = 0; clr_wr = 0; clr_val = 0; irq_en = 1;
    repeat (2) @(posedge clk);
    mh = '0; mfill = 0; mz = 0; exp_flag = 1'b0;
    @(negedge clk);
    check(viol_flag, 1'b0, "R9", "flag in reset");
    check(irq, 1'b0, "R9", "irq in reset");
    rst_n = 1'b1;
  endtask

  task automatic sparse_fill(input int groups, input string tag);
    for (int g = 0; g < groups; g++) begin
      cyc(1, 1, 0, 0, 1, tag);
      for (int i = 0; i < 7; i++) cyc(1, 0, 0, 0, 1, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));

    do_reset();
    cyc(0, 0, 0, 0, 1, "R9");
    check(viol_flag, 1'b0, "R9", "flag after reset");

    // Start-up prefix: 1, 15 zeros, 1, 7 zeros -> 24 bits, no full window short
    cyc(1, 1, 0, 0, 1, "R3");
    for (int i = 0; i < 15; i++) cyc(1, 0, 0, 0, 1, "R3");
    cyc(1, 1, 0, 0, 1, "R3");
    for (int i = 0; i < 7; i++) cyc(1, 0, 0, 0, 1, "R3");
    check(viol_flag, 1'b0, "R3", "no flag while windows partial");
    // bit 25: 24-bit window now holds one 1 -> violation
    cyc(1, 0, 0, 0, 1, "R2");
    check(viol_flag, 1'b1, "R2", "24-bit window short of ones");

    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 1, "R4");
    for (int i = 0; i < 8; i++) cyc(1, 1, 0, 0, 1, "R4");
    check(viol_flag, 1'b1, "R4", "flag held after stream recovers");

    cyc(0, 0, 1, 0, 1, "R5");
    check(viol_flag, 1'b1, "R5", "write of 0 ignored");
    cyc(0, 0, 0, 1, 1, "R5");
    check(viol_flag, 1'b1, "R5", "value without strobe ignored");
    cyc(0, 0, 1, 1, 1, "R5");
    check(viol_flag, 1'b0, "R5", "write of 1 clears");

    do_reset();
    sparse_fill(26, "R10");
    check(viol_flag, 1'b0, "R10", "one-in-eight stream compliant");
    cyc(1, 1, 0, 0, 1, "R1");
    for (int i = 0; i < 15; i++) cyc(1, 0, 0, 0, 1, "R1");
    check(viol_flag, 1'b0, "R1", "15 zeros allowed");
    cyc(1, 0, 0, 0, 1, "R1");
    check(viol_flag, 1'b1, "R1", "16th zero flags");

    cyc(1, 0, 1, 1, 1, "R6");
    check(viol_flag, 1'b1, "R6", "violation beats clear");
    cyc(0, 0, 1, 1, 0, "R5");
    check(viol_flag, 1'b0, "R5", "clear with no violation");

    cyc(1, 0, 0, 0, 0, "R7");
    check(viol_flag, 1'b1, "R7", "flag set");
    check(irq, 1'b0, "R7", "irq masked");
    cyc(0, 0, 0, 0, 1, "R7");
    check(irq, 1'b1, "R7", "irq enabled");

    do_reset();
    sparse_fill(25, "R8");
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 1, "R8");
    sparse_fill(5, "R8");
    check(viol_flag, 1'b0, "R8", "invalid zeros ignored");

    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int i = 0; i < 2000; i++) begin
        bit v  = ($urandom % 10) < 8;
        bit d  = ($urandom % 6) == 0;
        bit cw = ($urandom % 16) == 0;
        bit cv = ($urandom % 2) == 0;
        bit en = ($urandom % 2) == 0;
        cyc(v, d, cw, cv, en, "R2,R4");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule